// File: doc/BRIEF.md
# Region Protection and Translation Unit

This block gives a core without a paging MMU coarse memory protection and a simple address remap. The virtual address space is cut into a fixed number of equal regions, selected by the top address bits; each region holds a physical base and a four-bit attribute code. With the default parameters there are eight regions of 512 MB each.

A request carries a virtual address and an access kind (load, store or fetch). The unit looks up the region combinationally and decides whether the attribute permits that kind of access. One cycle later it presents either the translated physical address or a fault cause.

A configuration write port replaces the physical base and the attribute of one region. A write applies to requests issued after it. A request in the same cycle as a write still sees the old entry.

Top module: `region_guard`

## Requirements
- R1: The region used for a request is selected by the top SEL_W bits of `req_vaddr` (bits 31:29 by default).
- R2: After reset, region i has physical base i (its top address bits equal its own index, an identity map) and attribute code 2.
- R3: Loads and stores are permitted when the attribute is 0, 1, 2, 4, 5 or 14, and denied for every other code.
- R4: Fetches are permitted when the attribute lies between 1 and 5 inclusive, and denied otherwise.
- R5: On a permitted access, `rsp_paddr` is the region's physical base in the top SEL_W bits ORed with the low VA_W-SEL_W bits of the virtual address. On a fault, `rsp_paddr` is zero.
- R6: The access kind is encoded as 0 = load, 1 = store, 2 = fetch, 3 = reserved; a reserved kind is always denied. On a denial `rsp_fault` is 1 and `rsp_cause` is 1 for a load, 3 for a fetch, and 2 for a store or a reserved kind. On a permitted access `rsp_cause` is 0.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_fault`, `rsp_cause` and `rsp_paddr` are zero. All outputs are zero during reset and in the first cycle after it.
- R8: A configuration write (`cfg_we`) changes region `cfg_idx` at the clock edge. A request issued in the same cycle uses the old entry; requests in later cycles use the new one.
- R9: `cfg_pbase` supplies the top SEL_W bits of the region's physical base, and `cfg_attr` supplies its attribute code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| cfg_we | input | 1 | Region update strobe |
| cfg_idx | input | SEL_W | Region to update |
| cfg_pbase | input | SEL_W | New physical base (top address bits) |
| cfg_attr | input | 4 | New attribute code |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | VA_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 2 | 0 none, 1 load denied, 2 store denied, 3 fetch denied |

## Verification
The bench uses the default parameters: a 32-bit address and three select bits, which give eight regions. Eight regions are few enough that random updates hit every region often. They also let random requests land on freshly rewritten regions, so the behaviour of a write followed by a request, and of a write in the same cycle as a request, shows up many times. All sixteen attribute codes are swept against all four access kinds, which covers both permission decodes and every cause value.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    localparam int ATTR_W = 4;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'd0,
        CAUSE_LOAD_DENY   = 2'd1,
        CAUSE_STORE_DENY  = 2'd2,
        CAUSE_FETCH_DENY  = 2'd3
    } cause_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    // Data permission and execute permission are decoded independently.
    function automatic perm_t attr_perm(input logic [ATTR_W-1:0] a);
        perm_t p;
        logic  data_ok;
        data_ok = ((a < 4'd6) && (a != 4'd3)) || (a == 4'd14);
        p.rd = data_ok;
        p.wr = data_ok;
        p.ex = (a >= 4'd1) && (a <= 4'd5);
        return p;
    endfunction

    function automatic cause_e deny_cause(input acc_kind_e k);
        case (k)
            ACC_LOAD:  return CAUSE_LOAD_DENY;
            ACC_FETCH: return CAUSE_FETCH_DENY;
            default:   return CAUSE_STORE_DENY;
        endcase
    endfunction

endpackage

// File: rtl/rgn_table.sv
module rgn_table
    import rgn_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_pbase,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [SEL_W-1:0]  rd_idx,
    output logic [SEL_W-1:0]  rd_pbase,
    output logic [ATTR_W-1:0] rd_attr
);
    localparam int NREG = 1 << SEL_W;
    localparam logic [ATTR_W-1:0] RESET_ATTR = 4'd2;

    logic [SEL_W-1:0]  pbase_q [NREG];
    logic [ATTR_W-1:0] attr_q  [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                pbase_q[i] <= SEL_W'(i);
                attr_q[i]  <= RESET_ATTR;
            end else if (wr_en && (wr_idx == SEL_W'(i))) begin
                pbase_q[i] <= wr_pbase;
                attr_q[i]  <= wr_attr;
            end
        end
    end

    assign rd_pbase = pbase_q[rd_idx];
    assign rd_attr  = attr_q[rd_idx];

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (attr_q[$past(wr_idx)] == $past(wr_attr)) &&
                  (pbase_q[$past(wr_idx)] == $past(wr_pbase))); // R8

endmodule

// File: rtl/rgn_perm_check.sv
module rgn_perm_check
    import rgn_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  logic [1:0]        kind,
    output logic              grant,
    output logic [1:0]        cause
);
    perm_t     p;
    acc_kind_e k;

    always_comb begin
        p = attr_perm(attr);
        k = acc_kind_e'(kind);
        case (k)
            ACC_LOAD:  grant = p.rd;
            ACC_STORE: grant = p.wr;
            ACC_FETCH: grant = p.ex;
            default:   grant = 1'b0;
        endcase
        cause = grant ? CAUSE_NONE : deny_cause(k);
    end

endmodule

// File: rtl/rgn_resp_stage.sv
module rgn_resp_stage
    import rgn_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_grant,
    input  logic [1:0]       in_cause,
    input  logic [SEL_W-1:0] in_pbase,
    input  logic [VA_W-SEL_W-1:0] in_ofs,
    output logic             out_valid,
    output logic [VA_W-1:0]  out_paddr,
    output logic             out_fault,
    output logic [1:0]       out_cause
);
    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            out_valid <= 1'b0;
            out_paddr <= '0;
            out_fault <= 1'b0;
            out_cause <= CAUSE_NONE;
        end else begin
            out_valid <= 1'b1;
            out_fault <= !in_grant;
            out_cause <= in_cause;
            out_paddr <= in_grant ? {in_pbase, in_ofs} : '0;
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgn_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [SEL_W-1:0]  cfg_pbase,
    input  logic [3:0]        cfg_attr,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause
);
    localparam int OFS_W = VA_W - SEL_W;

    logic [SEL_W-1:0]  sel;
    logic [OFS_W-1:0]  ofs;
    logic [SEL_W-1:0]  ent_pbase;
    logic [ATTR_W-1:0] ent_attr;
    logic              grant;
    logic [1:0]        cause;

    assign sel = req_vaddr[VA_W-1 -: SEL_W];
    assign ofs = req_vaddr[OFS_W-1:0];

    rgn_table #(.SEL_W(SEL_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_pbase (cfg_pbase),
        .wr_attr  (cfg_attr),
        .rd_idx   (sel),
        .rd_pbase (ent_pbase),
        .rd_attr  (ent_attr)
    );

    rgn_perm_check perm_i (
        .attr  (ent_attr),
        .kind  (req_kind),
        .grant (grant),
        .cause (cause)
    );

    rgn_resp_stage #(.VA_W(VA_W), .SEL_W(SEL_W)) resp_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_grant  (grant),
        .in_cause  (cause),
        .in_pbase  (ent_pbase),
        .in_ofs    (ofs),
        .out_valid (rsp_valid),
        .out_paddr (rsp_paddr),
        .out_fault (rsp_fault),
        .out_cause (rsp_cause)
    );

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid))); // R7

    AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_fault && rsp_cause == 2'd0 && rsp_paddr == '0)); // R7

    AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_valid && !rsp_fault) |->
            (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))); // R5

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0))); // R6

    AST_RSVD_DENIED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && $past(req_kind) == 2'd3) |->
            (rsp_fault && rsp_cause == 2'd2)); // R6

    AST_FAULT_PADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_paddr == '0)); // R5

endmodule

// File: tb/region_guard_tb_top.sv
module region_guard_tb_top;
    localparam int VA_W  = 32;
    localparam int SEL_W = 3;
    localparam int NREG  = 1 << SEL_W;
    localparam int OFS_W = VA_W - SEL_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic [VA_W-1:0]  req_vaddr;
    logic [1:0]       req_kind;
    logic             cfg_we;
    logic [SEL_W-1:0] cfg_idx;
    logic [SEL_W-1:0] cfg_pbase;
    logic [3:0]       cfg_attr;
    logic             rsp_valid;
    logic [VA_W-1:0]  rsp_paddr;
    logic             rsp_fault;
    logic [1:0]       rsp_cause;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [SEL_W-1:0] m_pb [NREG];
    logic [3:0]       m_at [NREG];

    always #5 clk = ~clk;

    region_guard #(.VA_W(VA_W), .SEL_W(SEL_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_pbase(cfg_pbase), .cfg_attr(cfg_attr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    function automatic bit exp_grant(input logic [3:0] a, input logic [1:0] k);
        bit data_ok = ((a < 6) && (a != 3)) || (a == 14);
        bit ex_ok   = (a >= 1) && (a <= 5);
        case (k)
            2'd0, 2'd1: return data_ok;
            2'd2:       return ex_ok;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [1:0] exp_cause(input logic [3:0] a, input logic [1:0] k);
        if (exp_grant(a, k)) return 2'd0;
        if (k == 2'd0) return 2'd1;
        if (k == 2'd2) return 2'd3;
        return 2'd2;
    endfunction

    task automatic check(input string tag, input logic ev, input logic ef,
                         input logic [1:0] ec, input logic [VA_W-1:0] ep);
        n_run++;
        if (rsp_valid !== ev || rsp_fault !== ef || rsp_cause !== ec || rsp_paddr !== ep) begin
            n_fail++;
            $display("FAIL %s: got v=%0b f=%0b c=%0d pa=%h, expected v=%0b f=%0b c=%0d pa=%h",
                     tag, rsp_valid, rsp_fault, rsp_cause, rsp_paddr, ev, ef, ec, ep);
        end
    endtask

    // Called at a negedge: drive, cross the edge, update model, check at next negedge.
    task automatic step(input string tag, input logic rv, input logic [VA_W-1:0] va,
                        input logic [1:0] k, input logic we, input logic [SEL_W-1:0] wi,
                        input logic [SEL_W-1:0] wp, input logic [3:0] wa);
        logic [SEL_W-1:0] s;
        logic             g;
        logic             ev, ef;
        logic [1:0]       ec;
        logic [VA_W-1:0]  ep;
        req_valid = rv; req_vaddr = va; req_kind = k;
        cfg_we = we; cfg_idx = wi; cfg_pbase = wp; cfg_attr = wa;
        s  = va[VA_W-1 -: SEL_W];
        g  = exp_grant(m_at[s], k);
        ev = rv;
        ef = rv && !g;
        ec = rv ? exp_cause(m_at[s], k) : 2'd0;
        ep = (rv && g) ? {m_pb[s], va[OFS_W-1:0]} : '0;
        @(posedge clk);
        if (we) begin m_pb[wi] = wp; m_at[wi] = wa; end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        check(tag, ev, ef, ec, ep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b1; req_vaddr = '0; req_kind = 2'd0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_pbase = '0; cfg_attr = '0;
        for (int i = 0; i < NREG; i++) begin m_pb[i] = SEL_W'(i); m_at[i] = 4'd2; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset outputs", 1'b0, 1'b0, 2'd0, '0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R7 first cycle after reset", 1'b0, 1'b0, 2'd0, '0);

        // R2 identity map and attribute 2: every kind except reserved allowed
        for (int r = 0; r < NREG; r++) begin
            step("R2 R1 reset map load", 1'b1, {SEL_W'(r), 29'h0ABC_1234}, 2'd0, 1'b0, '0, '0, '0);
            step("R2 reset map fetch", 1'b1, {SEL_W'(r), 29'h1FFF_FFFF}, 2'd2, 1'b0, '0, '0, '0);
        end
        step("R6 reserved kind denied", 1'b1, 32'h4000_0010, 2'd3, 1'b0, '0, '0, '0);
        step("R7 idle no response", 1'b0, 32'h4000_0010, 2'd0, 1'b0, '0, '0, '0);

        // R3 R4 R6 sweep all attributes on region 5 remapped to base 2
        for (int a = 0; a < 16; a++) begin
            step("R9 write region", 1'b0, '0, 2'd0, 1'b1, 3'd5, 3'd2, 4'(a));
            for (int k = 0; k < 4; k++)
                step("R3 R4 R6 attr sweep", 1'b1, {3'd5, 29'h0123_4567}, 2'(k),
                     1'b0, '0, '0, '0);
        end

        // R8 same-cycle write and request: old entry used, then new
        step("R8 setup", 1'b0, '0, 2'd0, 1'b1, 3'd1, 3'd7, 4'd2);
        step("R8 same cycle sees old", 1'b1, 32'h2000_0040, 2'd1, 1'b1, 3'd1, 3'd3, 4'd9);
        step("R8 next cycle sees new", 1'b1, 32'h2000_0040, 2'd1, 1'b0, '0, '0, '0);
        step("R8 new base fetch", 1'b1, 32'h2000_0040, 2'd2, 1'b1, 3'd1, 3'd3, 4'd4);
        step("R5 R8 remapped", 1'b1, 32'h3FFF_FFFC, 2'd2, 1'b0, '0, '0, '0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] ra;
            ra = ($urandom_range(0, 3) == 0) ? 4'd14 : 4'($urandom_range(0, 15));
            step("R1 R3 R4 R5 R6 R8 random", 1'($urandom_range(0, 7) != 0), $urandom,
                 2'($urandom_range(0, 3)), 1'($urandom_range(0, 2) == 0),
                 SEL_W'($urandom_range(0, NREG - 1)), SEL_W'($urandom_range(0, NREG - 1)), ra);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule